// File: doc/BRIEF.md
# Barrel-Threaded SIMD Multiply-Accumulate Pipeline

This block is the arithmetic core of an interleaved multithreaded vector unit. Up to eight hardware threads each present an instruction on their own request line; a rotating issue slot visits thread 0, 1, … 7 in a fixed order, one slot per clock. Only the thread that owns the current slot may issue, and only if it is requesting. An empty slot is simply a bubble.

Issued instructions flow through eight stages (decode, register read, two multiply stages, two add stages, a transfer stage, write-back), each stage tagged with a valid bit and the thread number. Every thread owns a private bank of eight vector registers of four 16-bit lanes. Because a thread can issue at most once every eight cycles and the pipeline is eight deep, a result is always in its bank before the same thread can read it again. As a result, the block has neither interlocks nor forwarding paths.

Instruction word layout (30 bits): op `[1:0]`, rd `[4:2]`, ra `[7:5]`, rb `[10:8]`, rc `[13:11]`, imm `[29:14]`. The word of thread t sits at bits `[30t+29:30t]` of `instr_i`.

Top module: `vmx_barrel_top`

## Requirements
- R1: An issue slot counter starts at 0 and advances by one every clock, wrapping from 7 to 0. `grant_o[t]` is high exactly when the slot equals t and `req_i[t]` is high, so at most one grant bit is set in any cycle.
- R2: When the owner of the current slot is not requesting, nothing issues, no other thread takes the slot, and `wb_valid_o` stays low eight cycles later.
- R3: An instruction granted in cycle c shows on the write-back outputs in cycle c+8 with `wb_valid_o` high, `wb_tid_o` set to its thread, and `wb_rd_o` set to its rd field. The destination register takes `wb_data_o` at the end of that cycle.
- R4: Fields are decoded from the instruction word with the layout op `[1:0]`, rd `[4:2]`, ra `[7:5]`, rb `[10:8]`, rc `[13:11]`, imm `[29:14]`.
- R5: For op 1 (multiply), each lane gets bits `[30:15]` of the signed 32-bit product of the ra and rb lanes (Q1.15 with truncation). For example, 0x8000 times 0x8000 gives 0x8000.
- R6: For op 2 (multiply-accumulate), each lane gets the rc lane plus the R5 product, wrapping modulo 2^16.
- R7: For op 3 (multiply-subtract), each lane gets the rc lane minus the R5 product, wrapping modulo 2^16.
- R8: For op 0 (lane insert), the result is register ra with the lane selected by `rb[1:0]` replaced by imm. The other three lanes are copied unchanged.
- R9: Lane k occupies bits `[16k+15:16k]` of every register and of `wb_data_o`. Lanes are computed independently of each other.
- R10: A write-back updates only the register bank of the writing thread. The same register number in every other thread's bank is untouched.
- R11: An instruction issued in a thread's very next slot, eight cycles after the previous one, reads that previous instruction's result. It is granted without any stall.
- R12: During reset and right after it, the slot counter is 0, `wb_valid_o` is low, and every register of every bank reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NTHR | Per-thread instruction-present flag |
| instr_i | input | 30*NTHR | Per-thread instruction words, thread t at bits [30t+29:30t] |
| grant_o | output | NTHR | One-hot issue acknowledge for the current slot |
| wb_valid_o | output | 1 | Write-back stage holds a valid instruction |
| wb_tid_o | output | 3 | Thread of the write-back instruction |
| wb_rd_o | output | 3 | Destination register of the write-back instruction |
| wb_data_o | output | 64 | Four-lane result being written |

## Verification
The critical coincidence is a write-back of thread t landing on the same clock edge that thread t's next instruction enters decode. It is closely followed by that instruction reading the freshly written register. This is provoked by holding every request line high so that every thread issues in every one of its slots, and by a directed chain of dependent accumulate and subtract operations in one thread. The bench judges it by comparing each write-back against a per-thread register model that is updated in program order at grant time. It also checks that successive grants of the chained thread are exactly eight cycles apart.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
    localparam int LANES = 4;
    localparam int LW    = 16;
    localparam int RAW   = 3;
    localparam int NREG  = 1 << RAW;
    localparam int OPW   = 2;
    localparam int IMMW  = 16;
    localparam int SLOTS = 8;
    localparam int TIDW  = $clog2(SLOTS);
    localparam int SELW  = $clog2(LANES);
    localparam int IW    = OPW + 4 * RAW + IMMW;
    localparam int VW    = LANES * LW;

    typedef enum logic [OPW-1:0] {
        OP_INS = 2'd0,
        OP_MUL = 2'd1,
        OP_MAC = 2'd2,
        OP_MSC = 2'd3
    } op_e;

    typedef logic [LANES-1:0][LW-1:0] vec_t;

    typedef struct packed {
        logic                         vld;
        logic [TIDW-1:0]              tid;
        logic [IW-1:0]                raw;
        op_e                          op;
        logic [RAW-1:0]               rd;
        logic [RAW-1:0]               ra;
        logic [RAW-1:0]               rb;
        logic [RAW-1:0]               rc;
        logic [IMMW-1:0]              imm;
        vec_t                         a;
        vec_t                         b;
        vec_t                         c;
        logic [LANES-1:0][2*LW-1:0]   prod;
        vec_t                         scl;
        vec_t                         res;
    } stage_t;
endpackage

// File: rtl/vmx_sched.sv
module vmx_sched
    import vmx_pkg::*;
#(
    parameter int NTHR = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NTHR-1:0]  req_i,
    output logic [NTHR-1:0]  grant_o,
    output logic [TIDW-1:0]  tid_o,
    output logic             issue_o
);
    typedef struct packed {
        logic [TIDW-1:0] tok;
    } sch_t;

    sch_t sch_d, sch_q;

    always_comb begin
        sch_d = sch_q;
        sch_d.tok = (sch_q.tok == TIDW'(SLOTS - 1)) ? '0 : sch_q.tok + TIDW'(1);
        for (int t = 0; t < NTHR; t++) begin
            grant_o[t] = req_i[t] && (sch_q.tok == TIDW'(t));
        end
        tid_o   = sch_q.tok;
        issue_o = |grant_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sch_q <= '0;
        else         sch_q <= sch_d;
    end

    // R1: never more than one thread issues per cycle
    p_one_issue_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o));

    // R2: a slot is never handed to a thread that is not requesting
    p_grant_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o & ~req_i) == '0);
endmodule

// File: rtl/vmx_lane.sv
module vmx_lane
    import vmx_pkg::*;
#(
    parameter int LIDX = 0
) (
    // multiply 1 inputs
    input  logic [LW-1:0]    ma_i,
    input  logic [LW-1:0]    mb_i,
    output logic [2*LW-1:0]  prod_o,
    // multiply 2 inputs
    input  logic [2*LW-1:0]  prod_i,
    output logic [LW-1:0]    scl_o,
    // add 1 inputs
    input  op_e              op_i,
    input  logic [SELW-1:0]  sel_i,
    input  logic [IMMW-1:0]  imm_i,
    input  logic [LW-1:0]    a_i,
    input  logic [LW-1:0]    c_i,
    input  logic [LW-1:0]    scl_i,
    output logic [LW-1:0]    res_o
);
    logic unused_bits;

    always_comb begin
        prod_o = $signed(ma_i) * $signed(mb_i);
        // Q1.15 scaling by truncation
        scl_o  = prod_i[2*LW-2:LW-1];
        unique case (op_i)
            OP_INS:  res_o = (sel_i == SELW'(LIDX)) ? imm_i : a_i;
            OP_MUL:  res_o = scl_i;
            OP_MAC:  res_o = c_i + scl_i;
            default: res_o = c_i - scl_i;
        endcase
    end

    assign unused_bits = ^{prod_i[2*LW-1], prod_i[LW-2:0]};
endmodule

// File: rtl/vmx_rf.sv
module vmx_rf
    import vmx_pkg::*;
#(
    parameter int NTHR = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [TIDW-1:0]  rtid_i,
    input  logic [RAW-1:0]   ra_i,
    input  logic [RAW-1:0]   rb_i,
    input  logic [RAW-1:0]   rc_i,
    output vec_t             a_o,
    output vec_t             b_o,
    output vec_t             c_o,
    input  logic             we_i,
    input  logic [TIDW-1:0]  wtid_i,
    input  logic [RAW-1:0]   wreg_i,
    input  vec_t             wdata_i
);
    vec_t bank_d [NTHR][NREG];
    vec_t bank_q [NTHR][NREG];

    always_comb begin
        bank_d = bank_q;
        if (we_i) bank_d[wtid_i][wreg_i] = wdata_i;
        a_o = bank_q[rtid_i][ra_i];
        b_o = bank_q[rtid_i][rb_i];
        c_o = bank_q[rtid_i][rc_i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int t = 0; t < NTHR; t++)
                for (int r = 0; r < NREG; r++)
                    bank_q[t][r] <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    // R10: a write leaves every other thread/register pair untouched
    for (genvar gt = 0; gt < NTHR; gt++) begin : g_iso_t
        for (genvar gr = 0; gr < NREG; gr++) begin : g_iso_r
            p_bank_iso_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (we_i && !(wtid_i == TIDW'(gt) && wreg_i == RAW'(gr)))
                |=> bank_q[gt][gr] == $past(bank_q[gt][gr]));
        end
    end
endmodule

// File: rtl/vmx_barrel_top.sv
module vmx_barrel_top
    import vmx_pkg::*;
#(
    parameter int NTHR = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NTHR-1:0]    req_i,
    input  logic [NTHR*IW-1:0] instr_i,
    output logic [NTHR-1:0]    grant_o,
    output logic               wb_valid_o,
    output logic [TIDW-1:0]    wb_tid_o,
    output logic [RAW-1:0]     wb_rd_o,
    output logic [VW-1:0]      wb_data_o
);
    // stage index: 0 decode, 1 read, 2 mpy1, 3 mpy2, 4 add1, 5 add2, 6 transfer, 7 write-back
    localparam int ST_DEC = 0;
    localparam int ST_RD  = 1;
    localparam int ST_M1  = 2;
    localparam int ST_M2  = 3;
    localparam int ST_A1  = 4;
    localparam int ST_WB  = SLOTS - 1;

    logic [IW-1:0]   instr_arr [NTHR];
    logic            issue;
    logic [TIDW-1:0] iss_tid;
    vec_t            rf_a, rf_b, rf_c;
    logic [LANES-1:0][2*LW-1:0] ln_prod;
    vec_t            ln_scl, ln_res;

    stage_t st_d [SLOTS];
    stage_t st_q [SLOTS];

    for (genvar gt = 0; gt < NTHR; gt++) begin : g_unpack
        assign instr_arr[gt] = instr_i[gt*IW +: IW];
    end

    vmx_sched #(.NTHR(NTHR)) u_sched (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (req_i),
        .grant_o (grant_o),
        .tid_o   (iss_tid),
        .issue_o (issue)
    );

    vmx_rf #(.NTHR(NTHR)) u_rf (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rtid_i  (st_q[ST_RD].tid),
        .ra_i    (st_q[ST_RD].ra),
        .rb_i    (st_q[ST_RD].rb),
        .rc_i    (st_q[ST_RD].rc),
        .a_o     (rf_a),
        .b_o     (rf_b),
        .c_o     (rf_c),
        .we_i    (st_q[ST_WB].vld),
        .wtid_i  (st_q[ST_WB].tid),
        .wreg_i  (st_q[ST_WB].rd),
        .wdata_i (st_q[ST_WB].res)
    );

    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        vmx_lane #(.LIDX(gl)) u_lane (
            .ma_i   (st_q[ST_M1].a[gl]),
            .mb_i   (st_q[ST_M1].b[gl]),
            .prod_o (ln_prod[gl]),
            .prod_i (st_q[ST_M2].prod[gl]),
            .scl_o  (ln_scl[gl]),
            .op_i   (st_q[ST_A1].op),
            .sel_i  (st_q[ST_A1].rb[SELW-1:0]),
            .imm_i  (st_q[ST_A1].imm),
            .a_i    (st_q[ST_A1].a[gl]),
            .c_i    (st_q[ST_A1].c[gl]),
            .scl_i  (st_q[ST_A1].scl[gl]),
            .res_o  (ln_res[gl])
        );
    end

    always_comb begin
        for (int k = 1; k < SLOTS; k++) st_d[k] = st_q[k-1];
        // issue into decode
        st_d[ST_DEC]     = '0;
        st_d[ST_DEC].vld = issue;
        st_d[ST_DEC].tid = iss_tid;
        for (int t = 0; t < NTHR; t++) begin
            if (grant_o[t]) st_d[ST_DEC].raw = instr_arr[t];
        end
        // decode -> read
        st_d[ST_RD].op  = op_e'(st_q[ST_DEC].raw[OPW-1:0]);
        st_d[ST_RD].rd  = st_q[ST_DEC].raw[OPW +: RAW];
        st_d[ST_RD].ra  = st_q[ST_DEC].raw[OPW + RAW +: RAW];
        st_d[ST_RD].rb  = st_q[ST_DEC].raw[OPW + 2*RAW +: RAW];
        st_d[ST_RD].rc  = st_q[ST_DEC].raw[OPW + 3*RAW +: RAW];
        st_d[ST_RD].imm = st_q[ST_DEC].raw[OPW + 4*RAW +: IMMW];
        // read -> mpy1
        st_d[ST_M1].a = rf_a;
        st_d[ST_M1].b = rf_b;
        st_d[ST_M1].c = rf_c;
        // mpy1 -> mpy2, mpy2 -> add1, add1 -> add2
        st_d[ST_M2].prod    = ln_prod;
        st_d[ST_A1].scl     = ln_scl;
        st_d[ST_A1 + 1].res = ln_res;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int k = 0; k < SLOTS; k++) st_q[k] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wb_valid_o = st_q[ST_WB].vld;
    assign wb_tid_o   = st_q[ST_WB].tid;
    assign wb_rd_o    = st_q[ST_WB].rd;
    assign wb_data_o  = st_q[ST_WB].res;

    // R3: every grant reaches write-back eight cycles later with its thread tag
    p_wb_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue |-> ##8 (wb_valid_o && wb_tid_o == $past(iss_tid, 8)));

    // R2: an empty slot yields an empty write-back slot
    p_idle_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue |-> ##8 !wb_valid_o);

    // R11: no two in-flight instructions of one thread, so no hazard can exist
    for (genvar gk = 1; gk < SLOTS; gk++) begin : g_clash
        p_no_clash_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            st_q[0].vld |-> !(st_q[gk].vld && st_q[gk].tid == st_q[0].tid));
    end
endmodule

// File: tb/vmx_barrel_top_tb_top.sv
module vmx_barrel_top_tb_top;
    import vmx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NTHR       = 8;
    localparam int QD         = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NTHR-1:0]    req = '0;
    logic [NTHR*IW-1:0] instr = '0;
    logic [NTHR-1:0]    grant;
    logic               wb_valid;
    logic [TIDW-1:0]    wb_tid;
    logic [RAW-1:0]     wb_rd;
    logic [VW-1:0]      wb_data;

    vmx_barrel_top #(.NTHR(NTHR)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .req_i      (req),
        .instr_i    (instr),
        .grant_o    (grant),
        .wb_valid_o (wb_valid),
        .wb_tid_o   (wb_tid),
        .wb_rd_o    (wb_rd),
        .wb_data_o  (wb_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0, cyc = 0, tok = 0, fill_pct = 0;
    bit done = 0;
    logic [VW-1:0] mreg [NTHR][NREG];
    logic [IW-1:0] pbuf [NTHR][QD];
    string         ptag [NTHR][QD];
    int            phead [NTHR];
    int            pcnt  [NTHR];
    bit            chain [NTHR];
    int            last_g [NTHR];
    bit            exp_v [16];
    logic [TIDW-1:0] exp_t [16];
    logic [RAW-1:0]  exp_r [16];
    logic [VW-1:0]   exp_d [16];
    string           exp_s [16];

    task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // R4 layout: op[1:0] rd[4:2] ra[7:5] rb[10:8] rc[13:11] imm[29:14]
    function automatic logic [IW-1:0] mk(input logic [1:0] op, input int rd, input int ra,
                                         input int rb, input int rc, input logic [15:0] imm);
        return {imm, RAW'(rc), RAW'(rb), RAW'(ra), RAW'(rd), op};
    endfunction

    function automatic logic [15:0] q15(input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] p;
        p = $signed(a) * $signed(b);
        return p[30:15];
    endfunction

    function automatic logic [VW-1:0] model_exec(input int t, input logic [IW-1:0] w);
        logic [VW-1:0] va, vb, vc, r;
        logic [15:0] p;
        va = mreg[t][w[7:5]];
        vb = mreg[t][w[10:8]];
        vc = mreg[t][w[13:11]];
        for (int k = 0; k < LANES; k++) begin
            p = q15(va[16*k +: 16], vb[16*k +: 16]);
            case (w[1:0])
                2'd0: r[16*k +: 16] = (w[9:8] == 2'(k)) ? w[29:14] : va[16*k +: 16];
                2'd1: r[16*k +: 16] = p;
                2'd2: r[16*k +: 16] = vc[16*k +: 16] + p;
                default: r[16*k +: 16] = vc[16*k +: 16] - p;
            endcase
        end
        return r;
    endfunction

    task automatic push(input int t, input logic [IW-1:0] w, input string tg);
        int slot;
        slot = (phead[t] + pcnt[t]) % QD;
        pbuf[t][slot] = w;
        ptag[t][slot] = tg;
        pcnt[t]++;
    endtask

    function automatic logic [IW-1:0] rnd_instr();
        logic [15:0] imm;
        int r;
        r = $urandom % 8;
        imm = (r == 0) ? 16'h8000 : (r == 1) ? 16'h7FFF : (r == 2) ? 16'hFFFF : 16'($urandom);
        r = $urandom % 100;
        return mk((r < 40) ? 2'd0 : 2'(1 + $urandom % 3), $urandom % 8, $urandom % 8,
                  $urandom % 8, $urandom % 8, imm);
    endfunction

    task automatic step();
        int s, d;
        logic [NTHR-1:0] eg;
        logic [IW-1:0] w;
        logic [VW-1:0] e;
        string nm;
        @(negedge clk);
        s = cyc % 16;
        if (exp_v[s])
            chk(wb_valid && wb_tid == exp_t[s] && wb_rd == exp_r[s] && wb_data == exp_d[s],
                {exp_s[s], " result (R3 R4 R9 R10)"}, {wb_valid, wb_tid, wb_rd, wb_data},
                {1'b1, exp_t[s], exp_r[s], exp_d[s]});
        else
            chk(!wb_valid, "R2 write-back in empty slot", 128'(wb_valid), 128'(0));
        exp_v[s] = 0;
        for (int t = 0; t < NTHR; t++) begin
            req[t] = (pcnt[t] != 0);
            instr[t*IW +: IW] = pbuf[t][phead[t]];
        end
        #1;
        eg = req[tok] ? NTHR'(1) << tok : '0;
        chk(grant == eg, "R1 R2 issue grant", 128'(grant), 128'(eg));
        for (int t = 0; t < NTHR; t++) begin
            if (grant[t] && pcnt[t] != 0) begin
                w = pbuf[t][phead[t]];
                e = model_exec(t, w);
                mreg[t][w[4:2]] = e;
                case (w[1:0])
                    2'd0: nm = "R8 insert";
                    2'd1: nm = "R5 multiply";
                    2'd2: nm = "R6 accumulate";
                    default: nm = "R7 subtract";
                endcase
                d = (cyc + 8) % 16;
                exp_v[d] = 1; exp_t[d] = TIDW'(t); exp_r[d] = w[4:2]; exp_d[d] = e;
                exp_s[d] = {ptag[t][phead[t]], nm};
                if (chain[t] && last_g[t] >= 0)
                    chk(cyc - last_g[t] == 8, "R11 dependent issue spacing",
                        128'(cyc - last_g[t]), 128'(8));
                last_g[t] = cyc;
                phead[t] = (phead[t] + 1) % QD;
                pcnt[t]--;
            end
        end
        for (int t = 0; t < NTHR; t++)
            if (pcnt[t] == 0 && ($urandom % 100) < fill_pct) push(t, rnd_instr(), "");
        tok = (tok + 1) % SLOTS;
        cyc++;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int t = 0; t < NTHR; t++) begin
            phead[t] = 0; pcnt[t] = 0; chain[t] = 0; last_g[t] = -1;
            for (int r = 0; r < NREG; r++) mreg[t][r] = '0;
            for (int i = 0; i < QD; i++) begin pbuf[t][i] = '0; ptag[t][i] = ""; end
        end
        for (int i = 0; i < 16; i++) exp_v[i] = 0;

        // R12: reset state
        req = '1;
        repeat (3) @(negedge clk);
        chk(!wb_valid, "R12 write-back idle in reset", 128'(wb_valid), 128'(0));
        chk(grant == NTHR'(1), "R12 slot 0 during reset", 128'(grant), 128'(1));
        req = '0;
        @(posedge clk); #2 rst_n = 1'b1;

        // directed dependent chain in thread 3 (R11), corner values (R5)
        chain[3] = 1;
        push(3, mk(2'd0, 1, 1, 0, 0, 16'h4000), "");
        push(3, mk(2'd0, 1, 1, 1, 0, 16'h8000), "");
        push(3, mk(2'd0, 1, 1, 2, 0, 16'h7FFF), "");
        push(3, mk(2'd0, 1, 1, 3, 0, 16'hC000), "");
        push(3, mk(2'd2, 2, 1, 1, 2, 16'h0), "R11 chain ");
        push(3, mk(2'd2, 2, 1, 1, 2, 16'h0), "R11 chain ");
        push(3, mk(2'd2, 2, 2, 1, 2, 16'h0), "R11 chain ");
        push(3, mk(2'd3, 2, 1, 2, 2, 16'h0), "R11 chain ");
        push(3, mk(2'd1, 3, 1, 1, 0, 16'h0), "R11 chain ");
        // untouched bank reads zero after reset
        push(6, mk(2'd3, 4, 5, 6, 7, 16'h1234), "R12 zero bank ");
        push(6, mk(2'd2, 5, 4, 4, 4, 16'h0), "R12 zero bank ");
        repeat (100) step();
        chain[3] = 0;

        // full load: every thread issues in every slot (R11 for all threads)
        for (int t = 0; t < NTHR; t++) begin chain[t] = 1; last_g[t] = -1; end
        fill_pct = 100;
        repeat (400) step();
        for (int t = 0; t < NTHR; t++) chain[t] = 0;

        // mixed random load with empty slots
        fill_pct = 55;
        repeat (3000) step();
        fill_pct = 10;
        repeat (600) step();
        fill_pct = 0;
        repeat (60) step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule